// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block moves a run of processor registers to or from memory, one 32-bit word per beat, for a core with sixteen 32-bit registers. A start strobe presents a 16-bit instruction. When it carries one of four block transfer operations, the block captures a base address from the register file. It then walks the transfer list at ascending word addresses. On each beat it reads or writes one register and issues one memory request. It stays on the same beat until memory signals ready.

There are two families. The quad family always handles r4 to r7, and its base address comes from the register named in the instruction. The multiple family handles every register from the named one up to r15, and its base address comes from r0. For each accepted operation the block also reports how many memory operations it counts and whether the operation is charged one extra cycle. Both values are held until the next accepted operation.

Top module: `blkxfer_seq`

## Requirements
- R1: An instruction is accepted only when bits [15:8] are zero and bits [7:4] are 4 (quad load), 5 (quad store), 6 (multiple load) or 7 (multiple store); bits [3:0] name register RD. On any other instruction the start strobe is ignored: busy stays low, no memory request is made, and the reported counts keep their values.
- R2: A quad operation takes its base address from register RD and transfers r4, r5, r6, r7 in that order.
- R3: A multiple operation takes its base address from r0 and transfers registers RD up to r15 in ascending order.
- R4: The first beat uses the base address, and each later beat uses an address 4 above the previous beat.
- R5: From the cycle after an operation is accepted, memOpCount reads 4 for the quad forms and 16 minus RD for the multiple forms. extraCycle reads 1 for the quad forms and 0 for the multiple forms. Both hold until the next accepted start.
- R6: A beat whose memory request meets memReady low is repeated in the next cycle with the same address and register.
- R7: A load beat writes memRdata into the beat's register in the same cycle that memReady is high. A store beat drives memWe high and puts that register's value on memWdata.
- R8: The base address is captured once at acceptance, so a load that overwrites the base register does not change the addresses of later beats.
- R9: done is high for exactly one cycle, in the cycle after the last beat completes. busy is high from the cycle after acceptance through that done cycle. A start strobe seen while busy is ignored.
- R10: After reset, busy, done, memReq, memWe and rfWrEn are low, and memOpCount and extraCycle are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start strobe, one cycle |
| instr | input | 16 | Instruction presented with the start strobe |
| rfRdAddr | output | 4 | Register file read address (base register while idle, beat register while transferring) |
| rfRdData | input | 32 | Combinational read data for rfRdAddr |
| rfWrEn | output | 1 | Register file write enable |
| rfWrAddr | output | 4 | Register file write address |
| rfWrData | output | 32 | Register file write data |
| memReq | output | 1 | Memory request for the current beat |
| memWe | output | 1 | Request is a store |
| memAddr | output | 32 | Word address of the current beat |
| memWdata | output | 32 | Store data |
| memRdata | input | 32 | Load data, valid while memReady is high |
| memReady | input | 1 | Memory accepts or completes the current beat |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| memOpCount | output | 5 | Memory operations counted for the last accepted operation |
| extraCycle | output | 1 | Extra cycle charged for the last accepted operation |

## Verification
The assertions assume that the register file answers a read in the same cycle and that memRdata is valid whenever memReady is high during a request. They also assume that memReady does not change between clock edges except just after one. The bench satisfies these assumptions with a combinational register model and a memory whose read word is a fixed function of the address. memReady is either held high or toggled by a counter that is updated just after each rising edge. Start strobes and instructions are changed only on falling edges, so acceptance never depends on the order of processes at an edge.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  localparam int NUM_REGS = 16;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int CNT_W    = $clog2(NUM_REGS + 1);
  localparam int QUAD_FIRST = 4;
  localparam int QUAD_LEN   = 4;

  typedef struct packed {
    logic capture;  // latch base, list and counts
    logic step;     // current beat completed
  } xferStrobe_t;

  typedef struct packed {
    logic             valid;
    logic             isLoad;
    logic             isQuad;
    logic [REG_W-1:0] baseReg;
    logic [REG_W-1:0] firstReg;
    logic [CNT_W-1:0] beats;
  } xferDecode_t;

  function automatic xferDecode_t decodeXfer(input logic [15:0] ins);
    xferDecode_t d;
    logic [REG_W-1:0] rd;
    rd         = ins[REG_W-1:0];
    d.valid    = (ins[15:8] == 8'h00) && (ins[7:6] == 2'b01);
    d.isQuad   = ~ins[5];
    d.isLoad   = ~ins[4];
    d.baseReg  = d.isQuad ? rd : '0;
    d.firstReg = d.isQuad ? REG_W'(QUAD_FIRST) : rd;
    d.beats    = d.isQuad ? CNT_W'(QUAD_LEN) : CNT_W'(NUM_REGS) - CNT_W'(rd);
    return d;
  endfunction
endpackage

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic             startOk,
  input  logic [CNT_W-1:0] beats,
  input  logic             memReady,
  output xferStrobe_t      strobe,
  output logic             memReq,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} state_t;
  state_t state;
  logic [CNT_W-1:0] remaining;

  always_comb begin
    strobe.capture = (state == S_IDLE) && startValid && startOk;
    strobe.step    = (state == S_XFER) && memReady;
  end

  assign memReq = (state == S_XFER);
  assign busy   = (state != S_IDLE);
  assign done   = (state == S_FIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (strobe.capture) begin
          remaining <= beats;
          state     <= S_XFER;
        end
        S_XFER: if (strobe.step) begin
          remaining <= remaining - CNT_W'(1);
          if (remaining == CNT_W'(1)) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && startOk) |=> busy);
  a_r1_idle_without_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(startValid && startOk)) |=> !busy);
  a_r6_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> memReq);
endmodule

// File: rtl/blkxfer_dpath.sv
module blkxfer_dpath
  import blkxfer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic              decLoad,
  input  logic              decQuad,
  input  logic [REG_W-1:0]  decBase,
  input  logic [REG_W-1:0]  decFirst,
  input  logic [CNT_W-1:0]  decBeats,
  input  logic              memReq,
  input  logic              memReady,
  input  logic [DATA_W-1:0] rfRdData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [REG_W-1:0]  rfRdAddr,
  output logic              rfWrEn,
  output logic [REG_W-1:0]  rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [CNT_W-1:0]  memOpCount,
  output logic              extraCycle
);
  logic [ADDR_W-1:0] curAddr;
  logic [REG_W-1:0]  curReg;
  logic              isLoad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr    <= '0;
      curReg     <= '0;
      isLoad     <= 1'b0;
      memOpCount <= '0;
      extraCycle <= 1'b0;
    end else if (strobe.capture) begin
      curAddr    <= ADDR_W'(rfRdData);
      curReg     <= decFirst;
      isLoad     <= decLoad;
      memOpCount <= decBeats;
      extraCycle <= decQuad;
    end else if (strobe.step) begin
      curAddr <= curAddr + ADDR_W'(WORD_BYTES);
      curReg  <= curReg + REG_W'(1);
    end
  end

  assign rfRdAddr = memReq ? curReg : decBase;
  assign memAddr  = curAddr;
  assign memWe    = memReq && !isLoad;
  assign memWdata = rfRdData;
  assign rfWrEn   = memReq && memReady && isLoad;
  assign rfWrAddr = curReg;
  assign rfWrData = memRdata;

  a_r4_addr_advance: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES));
  a_r6_beat_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> ($stable(memAddr) && $stable(rfWrAddr) && $stable(memWe)));
  a_r5_counts_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(memOpCount) && $stable(extraCycle)));
  a_r8_base_once: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !strobe.step) |=> $stable(memAddr));
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [15:0]       instr,
  output logic [REG_W-1:0]  rfRdAddr,
  input  logic [DATA_W-1:0] rfRdData,
  output logic              rfWrEn,
  output logic [REG_W-1:0]  rfWrAddr,
  output logic [DATA_W-1:0] rfWrData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  memOpCount,
  output logic              extraCycle
);
  xferDecode_t dec;
  xferStrobe_t strobe;

  assign dec = decodeXfer(instr);

  blkxfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOk(dec.valid),
    .beats(dec.beats), .memReady(memReady), .strobe(strobe),
    .memReq(memReq), .busy(busy), .done(done)
  );

  blkxfer_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .decLoad(dec.isLoad), .decQuad(dec.isQuad), .decBase(dec.baseReg),
    .decFirst(dec.firstReg), .decBeats(dec.beats),
    .memReq(memReq), .memReady(memReady), .rfRdData(rfRdData), .memRdata(memRdata),
    .rfRdAddr(rfRdAddr), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memOpCount(memOpCount), .extraCycle(extraCycle)
  );
endmodule

// File: tb/sim_blkxfer_seq.sv
`timescale 1ns/1ps
module sim_blkxfer_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic [15:0] instr = 16'h0;
  logic [3:0] rfRdAddr, rfWrAddr;
  logic [31:0] rfRdData, rfWrData, memAddr, memWdata, memRdata;
  logic rfWrEn, memReq, memWe, memReady, busy, done, extraCycle;
  logic [4:0] memOpCount;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] regs [16];
  logic stallMode = 1'b0;
  logic [7:0] cyc = '0;

  int nBeats;
  logic [31:0] bAddr [40];
  logic [3:0]  bReg  [40];
  logic        bWe   [40];
  logic [31:0] bData [40];
  int stallBad = 0;
  int loadBad = 0;
  logic prevStall = 1'b0;
  logic [31:0] prevAddr;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1234_0000;
  endfunction

  assign rfRdData = regs[rfRdAddr];
  assign memRdata = memFn(memAddr);
  assign memReady = !stallMode || cyc[0];

  always_ff @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (rfWrEn) regs[rfWrAddr] <= rfWrData;
  end

  blkxfer_seq u0 (.*);

  always @(negedge clk) begin
    if (prevStall && memAddr !== prevAddr) stallBad++;
    prevStall = memReq && !memReady;
    prevAddr  = memAddr;
    if (memReq && memReady && nBeats < 40) begin
      bAddr[nBeats] = memAddr;
      bWe[nBeats]   = memWe;
      bReg[nBeats]  = memWe ? rfRdAddr : rfWrAddr;
      bData[nBeats] = memWe ? memWdata : memRdata;
      if (!memWe && !(rfWrEn && rfWrData == memRdata)) loadBad++;
      nBeats++;
    end
  end

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [15:0] ins, output int busyCyc, output int doneCyc);
    bit seen = 0;
    busyCyc = 0; doneCyc = 0;
    @(negedge clk);
    nBeats = 0;
    startValid = 1'b1; instr = ins;
    @(negedge clk);
    startValid = 1'b0; instr = 16'hFFFF;
    for (int i = 0; i < 300; i++) begin
      if (busy) busyCyc++;
      if (done) begin doneCyc++; seen = 1; end
      @(negedge clk);
      if (seen && !done) break;
    end
  endtask

  task automatic checkBeats(input string req, input int n, input logic [3:0] first,
                            input logic [31:0] base, input bit store,
                            input logic [31:0] snap [16]);
    check(nBeats == n, req, "beat count", nBeats, n);
    for (int k = 0; k < n && k < nBeats; k++) begin
      check(bAddr[k] == base + 32'(4*k), "R4", "beat address", bAddr[k], base + 32'(4*k));
      check(bReg[k] == first + 4'(k), req, "beat register", bReg[k], first + 4'(k));
      check(bWe[k] == store, "R7", "beat direction", bWe[k], store);
      if (store)
        check(bData[k] == snap[first + 4'(k)], "R7", "store data", bData[k], snap[first + 4'(k)]);
      else
        check(regs[first + 4'(k)] == memFn(base + 32'(4*k)), "R7", "loaded register",
              regs[first + 4'(k)], memFn(base + 32'(4*k)));
    end
  endtask

  task automatic seedRegs();
    for (int r = 0; r < 16; r++) regs[r] = 32'hC0DE_0000 + 32'(r * 16'h111);
  endtask

  task automatic t_reset();
    check(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);
    check(!memReq && !memWe && !rfWrEn, "R10", "req/we after reset", {memReq, memWe, rfWrEn}, 0);
    check(memOpCount == 0 && !extraCycle, "R10", "counts after reset", {memOpCount, extraCycle}, 0);
  endtask

  task automatic t_quadLoad();
    int b, d;
    logic [31:0] snap [16];
    seedRegs(); regs[2] = 32'h100; snap = regs;
    runOp(16'h0042, b, d);
    checkBeats("R2", 4, 4'd4, 32'h100, 0, snap);
    check(memOpCount == 4, "R5", "quad op count", memOpCount, 4);
    check(extraCycle == 1, "R5", "quad extra cycle", extraCycle, 1);
    check(d == 1, "R9", "done pulse width", d, 1);
    check(b == 5, "R9", "busy cycles", b, 5);
    check(loadBad == 0, "R7", "load write same cycle", loadBad, 0);
  endtask

  task automatic t_quadStoreStall();
    int b, d;
    logic [31:0] snap [16];
    seedRegs(); regs[9] = 32'h2000; snap = regs;
    stallMode = 1'b1;
    runOp(16'h0059, b, d);
    stallMode = 1'b0;
    checkBeats("R6", 4, 4'd4, 32'h2000, 1, snap);
    check(b > 5, "R6", "stalled busy cycles", b, 6);
    check(stallBad == 0, "R6", "address held on stall", stallBad, 0);
    check(d == 1, "R9", "done pulse width under stall", d, 1);
  endtask

  task automatic t_multiLoad();
    int b, d;
    logic [31:0] snap [16];
    seedRegs(); regs[0] = 32'h340; snap = regs;
    runOp(16'h006C, b, d);
    checkBeats("R3", 4, 4'd12, 32'h340, 0, snap);
    check(memOpCount == 4, "R5", "multi rd12 count", memOpCount, 4);
    check(extraCycle == 0, "R5", "multi extra cycle", extraCycle, 0);
  endtask

  task automatic t_multiLoadAll();
    int b, d;
    logic [31:0] snap [16];
    seedRegs(); regs[0] = 32'h800; snap = regs;
    runOp(16'h0060, b, d);
    checkBeats("R8", 16, 4'd0, 32'h800, 0, snap);
    check(memOpCount == 16, "R5", "multi rd0 count", memOpCount, 16);
    check(b == 17, "R9", "busy cycles 16 beats", b, 17);
  endtask

  task automatic t_multiStoreOne();
    int b, d;
    logic [31:0] snap [16];
    seedRegs(); regs[0] = 32'hA0; snap = regs;
    runOp(16'h007F, b, d);
    checkBeats("R3", 1, 4'd15, 32'hA0, 1, snap);
    check(memOpCount == 1, "R5", "multi rd15 count", memOpCount, 1);
  endtask

  task automatic t_quadBaseOverwrite();
    int b, d;
    logic [31:0] snap [16];
    seedRegs(); regs[5] = 32'h600; snap = regs;
    runOp(16'h0045, b, d);
    checkBeats("R8", 4, 4'd4, 32'h600, 0, snap);
  endtask

  task automatic t_badInstr();
    logic [4:0] cnt0 = memOpCount;
    logic ext0 = extraCycle;
    int busySeen = 0;
    logic [15:0] bad [3] = '{16'h0034, 16'h0144, 16'h0084};
    foreach (bad[i]) begin
      @(negedge clk); startValid = 1'b1; instr = bad[i];
      @(negedge clk); startValid = 1'b0;
      for (int k = 0; k < 3; k++) begin
        if (busy || memReq) busySeen++;
        @(negedge clk);
      end
    end
    check(busySeen == 0, "R1", "busy/req on rejected instr", busySeen, 0);
    check(memOpCount == cnt0 && extraCycle == ext0, "R1", "counts kept on rejected instr",
          {memOpCount, extraCycle}, {cnt0, ext0});
  endtask

  task automatic t_startWhileBusy();
    int d = 0;
    seedRegs(); regs[0] = 32'h40;
    @(negedge clk); nBeats = 0; startValid = 1'b1; instr = 16'h006D;
    @(negedge clk); instr = 16'h0041;
    @(negedge clk); startValid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) d++;
      @(negedge clk);
    end
    check(nBeats == 3, "R9", "beats with start while busy", nBeats, 3);
    check(d == 1, "R9", "single done with start while busy", d, 1);
    check(memOpCount == 3, "R9", "count from first op", memOpCount, 3);
    check(!busy, "R9", "idle after op", busy, 0);
  endtask

  initial begin
    seedRegs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_quadLoad();
    t_quadStoreStall();
    t_multiLoad();
    t_multiLoadAll();
    t_multiStoreOne();
    t_quadBaseOverwrite();
    t_badInstr();
    t_startWhileBusy();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule